// File: doc/BRIEF.md
# Half-Duplex Serial Bus Slave

This block is the target end of a serial link that uses four wires: a clock driven by the master, an active-low select, one data line shared by both sides, and a status/acknowledge line that only the slave drives. While it is not selected, the slave uses the two lines it drives to advertise the state of its local buffers. The shared line shows whether the receive buffer can accept a byte. The acknowledge line shows whether the transmit buffer holds a byte.

Once selected, the slave releases the shared line at once. It shifts in a seven-bit command and leaves one clock for bus turnaround. It then moves one byte in the direction that the command asks for: it either pushes the byte into the receive buffer or pops a byte from the transmit buffer and drives it out. Throughout the byte it reports ACK or NAK on the acknowledge line. The bus clock, the select and the data input are synchronised into the system clock domain, and bus edges are found there. The bus clock must therefore run several times slower than the system clock.

The tri-state pad is modelled as separate input, output and output-enable signals. Each local buffer is a simple one-byte push or pop strobe with a full or empty flag.

Top module: `hdx_serial_slave`

## Requirements
- R1: While `bus_sel_n_i` is 1, `dio_oe` is 1, `dio_o` equals NOT `wr_full_i` (1 = room to receive), and `ack_o` equals NOT `rd_empty_i` (1 = a byte is ready to read).
- R2: When `bus_sel_n_i` goes to 0, `dio_oe` falls in the same cycle, with no clock edge needed. It stays 0 through the command and the turnaround.
- R3: The command is taken MSB first from `dio_i` on the first 7 rising edges of `bus_clk_i` after select. After the 7th edge it appears on `cmd_o` and is held there until the next command completes.
- R4: Command bit 0 picks the direction: 1 means a read (slave to master) and 0 means a write (master to slave). The other six bits have no effect on the transfer.
- R5: The 8th rising edge is the turnaround. The value on `dio_i` at that edge is not used.
- R6: In a write, rising edges 9 to 16 sample the byte MSB first. After edge 16 the byte is presented on `wr_byte_o` with a single-cycle `wr_push_o` pulse.
- R7: In a read, one `rd_pop_o` pulse takes `rd_byte_i` at the 8th rising edge. The slave drives `dio_oe` high from the first falling edge after that. It presents the byte MSB first, moving to the next bit after each falling edge that follows a data rising edge.
- R8: While selected, `ack_o` is 1 before the data phase. From the 8th rising edge until deselect, it holds 0 for ACK or 1 for NAK.
- R9: NAK is given for a write when `wr_full_i` is 1, or for a read when `rd_empty_i` is 1, sampled at the 8th rising edge. A NAKed transfer makes no push and no pop, and the slave does not drive the data line.
- R10: Deselecting before the 16th rising edge returns the slave to idle and discards the partial byte: no push occurs. The next transfer works normally.
- R11: `wr_push_o` and `rd_pop_o` are never high in the same cycle, and each is high for only one cycle per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_clk_i | input | 1 | Bus clock from the master |
| bus_sel_n_i | input | 1 | Active-low select from the master |
| dio_i | input | 1 | Shared data line, value seen at the pad |
| dio_o | output | 1 | Shared data line, value driven by the slave |
| dio_oe | output | 1 | Output enable for the shared data line |
| ack_o | output | 1 | Status when idle, ACK (0) or NAK (1) during data |
| cmd_o | output | 7 | Last command received |
| wr_full_i | input | 1 | Receive buffer full |
| wr_push_o | output | 1 | Push strobe for a received byte |
| wr_byte_o | output | 8 | Received byte |
| rd_empty_i | input | 1 | Transmit buffer empty |
| rd_pop_o | output | 1 | Pop strobe for the transmit buffer |
| rd_byte_i | input | 8 | Head byte of the transmit buffer |

## Verification
The hardest case to reach from the ports is a deselect in the middle of the data phase. Some bits have already been shifted in at that point, and a push would be wrong. The bench reaches it by running a write transfer that stops after four data clocks. It then checks that no push was seen and that the idle status lines come back, and runs a full write right afterwards to prove that no stale bit count carries over. NAK paths are reached by holding the full flag high during a write, and by emptying the transmit queue before a read.

// File: rtl/hdx_pkg.sv
// Package: types shared by the half-duplex serial slave.
// Assumes: nothing beyond IEEE 1800-2017.
package hdx_pkg;

    // Transfer phases of the slave sequencer
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_TURN,
        ST_DATA,
        ST_DONE
    } hdx_state_e;

endpackage

// File: rtl/hdx_sync.sv
// Module: multi-bit synchroniser, a chain of STAGES flops per bit.
// Assumes: every bit is an independent level; no bus coherency is implied.
module hdx_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the asynchronous input
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[s] <= RST_VAL;
                else        chain_q[s] <= d_i;
            end
        end else begin : g_next
            // Later stages settle metastability
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[s] <= RST_VAL;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hdx_edge.sv
// Module: finds rising and falling edges of a synchronised level.
// Assumes: input is already in the clk domain; the level idles low.
module hdx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;

    // Remember the level of the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/hdx_seq.sv
// Module: transfer sequencer. It shifts in the command, handles the
// turnaround, moves one data byte and decides between ACK and NAK.
// Assumes: the bus edge strobes are single-cycle pulses that never occur
// together, and select has been stable for a few cycles around each change.
module hdx_seq
    import hdx_pkg::*;
#(
    parameter int CMD_BITS  = 7,
    parameter int DATA_BITS = 8,
    parameter int RW_BIT    = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_n_s_i,
    input  logic                 rise_i,
    input  logic                 fall_i,
    input  logic                 din_s_i,
    input  logic                 wr_full_i,
    input  logic                 rd_empty_i,
    input  logic [DATA_BITS-1:0] rd_byte_i,
    output hdx_state_e           state_o,
    output logic [CMD_BITS-1:0]  cmd_o,
    output logic                 nak_o,
    output logic                 drv_o,
    output logic                 dbit_o,
    output logic                 push_o,
    output logic [DATA_BITS-1:0] push_byte_o,
    output logic                 pop_o
);
    localparam int MAXB = (CMD_BITS > DATA_BITS) ? CMD_BITS : DATA_BITS;
    localparam int CW   = $clog2(MAXB + 1);
    localparam logic [CW-1:0] CMD_LAST  = CW'(CMD_BITS - 1);
    localparam logic [CW-1:0] DATA_LAST = CW'(DATA_BITS - 1);

    hdx_state_e            state_q;
    logic [CW-1:0]         cnt_q;
    logic [CMD_BITS-1:0]   csh_q;
    logic [CMD_BITS-1:0]   cmd_q;
    logic [DATA_BITS-1:0]  dsh_q;
    logic                  nak_q;
    logic                  drv_q;
    logic                  push_q;
    logic                  pop_q;
    logic [DATA_BITS-1:0]  pbyte_q;
    logic                  is_read;
    logic [CMD_BITS-1:0]   csh_next;
    logic [DATA_BITS-1:0]  dsh_in;

    assign is_read  = cmd_q[RW_BIT];
    assign csh_next = {csh_q[CMD_BITS-2:0], din_s_i};
    assign dsh_in   = {dsh_q[DATA_BITS-2:0], din_s_i};

    // Phase sequencing, shifting and buffer strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            csh_q   <= '0;
            cmd_q   <= '0;
            dsh_q   <= '0;
            nak_q   <= 1'b1;
            drv_q   <= 1'b0;
            push_q  <= 1'b0;
            pop_q   <= 1'b0;
            pbyte_q <= '0;
        end else begin
            push_q <= 1'b0;
            pop_q  <= 1'b0;
            if (sel_n_s_i) begin
                state_q <= ST_IDLE;
                cnt_q   <= '0;
                drv_q   <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        state_q <= ST_CMD;
                        cnt_q   <= '0;
                    end
                    ST_CMD: if (rise_i) begin
                        csh_q <= csh_next;
                        if (cnt_q == CMD_LAST) begin
                            cmd_q   <= csh_next;
                            cnt_q   <= '0;
                            state_q <= ST_TURN;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_TURN: if (rise_i) begin
                        state_q <= ST_DATA;
                        cnt_q   <= '0;
                        if (is_read) begin
                            nak_q <= rd_empty_i;
                            pop_q <= ~rd_empty_i;
                            dsh_q <= rd_byte_i;
                        end else begin
                            nak_q <= wr_full_i;
                        end
                    end
                    ST_DATA: begin
                        if (rise_i) begin
                            if (!is_read) dsh_q <= dsh_in;
                            if (cnt_q == DATA_LAST) begin
                                state_q <= ST_DONE;
                                if (!is_read && !nak_q) begin
                                    push_q  <= 1'b1;
                                    pbyte_q <= dsh_in;
                                end
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end else if (fall_i && is_read && !nak_q) begin
                            if (!drv_q) drv_q <= 1'b1;
                            else        dsh_q <= dsh_q << 1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign state_o     = state_q;
    assign cmd_o       = cmd_q;
    assign nak_o       = nak_q;
    assign drv_o       = drv_q;
    assign dbit_o      = dsh_q[DATA_BITS-1];
    assign push_o      = push_q;
    assign push_byte_o = pbyte_q;
    assign pop_o       = pop_q;
endmodule

// File: rtl/hdx_serial_slave.sv
// Module: top of the half-duplex serial slave. It synchronises the bus
// pins, detects bus clock edges and muxes the status or the data onto the
// two slave-driven lines.
// Assumes: bus clock half period of at least 4 system clocks.
module hdx_serial_slave
    import hdx_pkg::*;
#(
    parameter int CMD_BITS    = 7,
    parameter int DATA_BITS   = 8,
    parameter int RW_BIT      = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_clk_i,
    input  logic                 bus_sel_n_i,
    input  logic                 dio_i,
    output logic                 dio_o,
    output logic                 dio_oe,
    output logic                 ack_o,
    output logic [CMD_BITS-1:0]  cmd_o,
    input  logic                 wr_full_i,
    output logic                 wr_push_o,
    output logic [DATA_BITS-1:0] wr_byte_o,
    input  logic                 rd_empty_i,
    output logic                 rd_pop_o,
    input  logic [DATA_BITS-1:0] rd_byte_i
);
    logic [2:0] pins_s;
    logic       sel_n_s;
    logic       din_s;
    logic       bclk_s;
    logic       rise;
    logic       fall;
    hdx_state_e state;
    logic       nak;
    logic       drv;
    logic       dbit;
    logic       in_data;

    hdx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({bus_sel_n_i, dio_i, bus_clk_i}),
        .q_o   (pins_s)
    );
    assign {sel_n_s, din_s, bclk_s} = pins_s;

    hdx_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (bclk_s),
        .rise_o (rise),
        .fall_o (fall)
    );

    hdx_seq #(.CMD_BITS(CMD_BITS), .DATA_BITS(DATA_BITS), .RW_BIT(RW_BIT)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_n_s_i   (sel_n_s),
        .rise_i      (rise),
        .fall_i      (fall),
        .din_s_i     (din_s),
        .wr_full_i   (wr_full_i),
        .rd_empty_i  (rd_empty_i),
        .rd_byte_i   (rd_byte_i),
        .state_o     (state),
        .cmd_o       (cmd_o),
        .nak_o       (nak),
        .drv_o       (drv),
        .dbit_o      (dbit),
        .push_o      (wr_push_o),
        .push_byte_o (wr_byte_o),
        .pop_o       (rd_pop_o)
    );

    assign in_data = (state == ST_DATA) || (state == ST_DONE);

    // Pad muxing: the raw select gates the drive, so release needs no edge
    always_comb begin
        if (bus_sel_n_i) begin
            dio_oe = 1'b1;
            dio_o  = ~wr_full_i;
            ack_o  = ~rd_empty_i;
        end else begin
            dio_oe = drv;
            dio_o  = dbit;
            ack_o  = in_data ? nak : 1'b1;
        end
    end
endmodule

// File: rtl/hdx_serial_slave_chk.sv
// Module: property checker for hdx_serial_slave, attached by bind.
// Assumes: it observes the top's ports and its sequencer state.
module hdx_serial_slave_chk
    import hdx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel_n_i,
    input logic       dio_oe,
    input logic       dio_o,
    input logic       ack_o,
    input logic       wr_full_i,
    input logic       rd_empty_i,
    input logic       wr_push_o,
    input logic       rd_pop_o,
    input hdx_state_e state
);
    p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel_n_i |-> (dio_oe && (dio_o == !wr_full_i) && (ack_o == !rd_empty_i)));

    p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel_n_i && state != ST_DATA && state != ST_DONE) |-> !dio_oe);

    p_ack_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel_n_i && $past(!bus_sel_n_i) && state == ST_DATA && $past(state) == ST_DATA)
        |-> $stable(ack_o));

    p_pop_acked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop_o && !bus_sel_n_i) |-> (!ack_o && state == ST_DATA));

    p_push_acked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_push_o && !bus_sel_n_i) |-> (!ack_o && state == ST_DONE));

    p_push_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_push_o |=> !wr_push_o);

    p_pop_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pop_o |=> !rd_pop_o);

    p_no_both_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_push_o && rd_pop_o));
endmodule

bind hdx_serial_slave hdx_serial_slave_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel_n_i (bus_sel_n_i),
    .dio_oe      (dio_oe),
    .dio_o       (dio_o),
    .ack_o       (ack_o),
    .wr_full_i   (wr_full_i),
    .rd_empty_i  (rd_empty_i),
    .wr_push_o   (wr_push_o),
    .rd_pop_o    (rd_pop_o),
    .state       (u_seq.state_o)
);

// File: tb/hdx_serial_slave_bench.sv
// Bench: behavioural master plus reference model. Idle lines and bus
// contention are compared on every clock; transfers are checked per bit.
module hdx_serial_slave_bench;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk = 1'b0;
    logic       sel_n = 1'b1;
    logic       mst_oe = 1'b0;
    logic       mst_d = 1'b1;
    logic       dio_i;
    logic       dio_o;
    logic       dio_oe;
    logic       ack_o;
    logic [6:0] cmd_o;
    logic       wr_full = 1'b0;
    logic       wr_push;
    logic [7:0] wr_byte;
    logic       rd_pop;
    logic [7:0] rd_byte;
    logic       rd_empty;

    int         total = 0;
    int         bad = 0;
    int         pushes = 0;
    int         pops = 0;
    bit         done = 1'b0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    always #10 clk = ~clk;

    assign dio_i    = mst_oe ? mst_d : (dio_oe ? dio_o : 1'b1);
    assign rd_empty = (txq.size() == 0);
    assign rd_byte  = rd_empty ? 8'h00 : txq[0];

    hdx_serial_slave u_hdx_serial_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_clk_i   (bclk),
        .bus_sel_n_i (sel_n),
        .dio_i       (dio_i),
        .dio_o       (dio_o),
        .dio_oe      (dio_oe),
        .ack_o       (ack_o),
        .cmd_o       (cmd_o),
        .wr_full_i   (wr_full),
        .wr_push_o   (wr_push),
        .wr_byte_o   (wr_byte),
        .rd_empty_i  (rd_empty),
        .rd_pop_o    (rd_pop),
        .rd_byte_i   (rd_byte)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Every-clock model: buffer strobes, idle status lines, no contention
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_pop)  begin pops++;  void'(txq.pop_front()); end
            if (wr_push) begin pushes++; rxq.push_back(wr_byte); end
            chk(!(wr_push && rd_pop), "R11 push and pop together", {wr_push, rd_pop}, 0);
            if (sel_n) begin
                chk(dio_oe == 1'b1, "R1 idle oe", dio_oe, 1);
                chk(dio_o == !wr_full, "R1 idle write status", dio_o, !wr_full);
                chk(ack_o == !rd_empty, "R1 idle read status", ack_o, !rd_empty);
            end
            if (mst_oe) chk(!dio_oe, "R2/R7 bus contention", dio_oe, 0);
        end
    end

    task automatic half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic pulse();
        half(); bclk = 1'b1; half(); bclk = 1'b0;
    endtask

    // One transfer; nbits < 8 deselects early
    task automatic xfer(input logic [6:0] cmd, input logic [7:0] wb, input int nbits,
                        output logic [7:0] rb, output logic ackv);
        bit rd;
        rd = cmd[0];
        rb = '0;
        ackv = 1'b1;
        sel_n = 1'b0;
        #1;
        chk(dio_oe == 1'b0, "R2 release without clock", dio_oe, 0);
        @(negedge clk);
        for (int i = 0; i < 7; i++) begin
            mst_oe = 1'b1; mst_d = cmd[6-i];
            chk(ack_o == 1'b1, "R8 ack high before data", ack_o, 1);
            pulse();
        end
        mst_oe = 1'b1; mst_d = ~mst_d;  // garbage during turnaround edge, R5
        half();
        chk(cmd_o == cmd, "R3 command captured", cmd_o, cmd);
        chk(dio_oe == 1'b0, "R2 released in turnaround", dio_oe, 0);
        mst_oe = 1'b0;
        bclk = 1'b1; half(); bclk = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            if (!rd) begin mst_oe = 1'b1; mst_d = wb[7-i]; end
            half();
            if (rd) begin
                rb[7-i] = dio_o;
                chk(dio_oe == !ack_o, "R7 drive follows ack", dio_oe, !ack_o);
            end
            bclk = 1'b1; half();
            if (i == 0) ackv = ack_o;
            bclk = 1'b0;
        end
        mst_oe = 1'b0;
        half(); half();
        sel_n = 1'b1;
        half();
    endtask

    initial begin
        logic [7:0] rb;
        logic       ackv;
        int         p0;
        repeat (4) @(negedge clk);
        chk(wr_push == 1'b0 && rd_pop == 1'b0, "R11 reset strobes", {wr_push, rd_pop}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dio_oe && dio_o == 1'b1 && ack_o == 1'b0, "R1 reset idle", {dio_oe, dio_o, ack_o}, 3'b110);
        // write ACK, R6 and R4 (bit0 = 0 write, upper bits arbitrary)
        xfer(7'b1011010, 8'hA5, 8, rb, ackv);
        chk(ackv == 1'b0, "R8 write ack", ackv, 0);
        chk(pushes == 1 && rxq.size() == 1, "R6 one push", pushes, 1);
        if (rxq.size() > 0) chk(rxq[rxq.size()-1] == 8'hA5, "R6 pushed byte", rxq[rxq.size()-1], 8'hA5);
        xfer(7'b0100110, 8'h3C, 8, rb, ackv);
        chk(pushes == 2, "R4 other bits ignored", pushes, 2);
        if (rxq.size() > 1) chk(rxq[1] == 8'h3C, "R6 second byte", rxq[1], 8'h3C);
        // read ACK, R7
        txq.push_back(8'h96); txq.push_back(8'h5B);
        half();
        xfer(7'b0000001, 8'h00, 8, rb, ackv);
        chk(ackv == 1'b0, "R8 read ack", ackv, 0);
        chk(rb == 8'h96, "R7 read byte", rb, 8'h96);
        chk(pops == 1 && txq.size() == 1, "R7 one pop", pops, 1);
        xfer(7'b1110011, 8'h00, 8, rb, ackv);
        chk(rb == 8'h5B, "R4 read with other bits set", rb, 8'h5B);
        // read NAK, R9
        xfer(7'b0000001, 8'h00, 8, rb, ackv);
        chk(ackv == 1'b1, "R9 read nak", ackv, 1);
        chk(pops == 2, "R9 no pop on nak", pops, 2);
        // write NAK, R9
        wr_full = 1'b1;
        half();
        xfer(7'b0000000, 8'hFF, 8, rb, ackv);
        chk(ackv == 1'b1, "R9 write nak", ackv, 1);
        chk(pushes == 2, "R9 no push on nak", pushes, 2);
        wr_full = 1'b0;
        half();
        // abort mid data, R10
        p0 = pushes;
        xfer(7'b0000000, 8'hC3, 4, rb, ackv);
        chk(pushes == p0, "R10 no push after abort", pushes, p0);
        chk(dio_oe == 1'b1 && dio_o == 1'b1, "R10 idle after abort", {dio_oe, dio_o}, 2'b11);
        xfer(7'b0000000, 8'h81, 8, rb, ackv);
        chk(pushes == p0 + 1, "R10 next transfer pushes", pushes, p0 + 1);
        if (rxq.size() > 0) chk(rxq[rxq.size()-1] == 8'h81, "R10 clean byte", rxq[rxq.size()-1], 8'h81);
        chk(pops == 2, "R11 pop count", pops, 2);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule